// File: doc/BRIEF.md
# Banked Uncore Performance Counter Unit

This block is a performance-monitor register file for a subsystem with several processor clusters and one shared fabric. It holds five monitor banks: one for each of four clusters and one for the shared fabric. Each bank has two 32-bit event counters. Every counter has an event-type register that picks which of the bank's eight single-cycle event lines it counts.

Software reaches every bank through one shared window of per-bank registers. A global select register steers that window to one bank. Writes take effect at the clock edge. Reads are combinational from the address.

Each bank has a power-down input. While it is asserted, the bank reads back all ones, so software can tell that the bank is off, and writes to the bank have no effect. One interrupt line reports any overflow whose interrupt is enabled.

Top module: `uncore_perfmon_bank`

## Requirements
- R1: The select register is at address 0x0 and reads back its 12 bits. Value 0x100+k (k = 0..3) steers the window to cluster bank k. Value 0x000 steers it to the fabric bank. Any other value steers it to nothing: per-bank reads return 0 and per-bank writes change no state.
- R2: After reset, every register of every bank reads 0 and the select register is 0x000.
- R3: A counter increments by one in a cycle when all of these hold: the bank run bit is 1, the counter's enable bit is 1, the bank is powered, and its selected event line is high.
- R4: The event-type register (address 0x8 for counter 0, 0x9 for counter 1) selects event line t of the bank for values t = 0..7. Values of 8 and above count nothing.
- R5: Enables use write-one semantics. A write to 0x1 sets enable bit i for each 1 in data bit i. A write to 0x2 clears enable bit i for each 1 in data bit i. Zero bits leave the enables unchanged. Both addresses read the enable bits.
- R6: At control address 0x7, data bit 0 is the bank run bit. Writing 1 in data bit 1 zeroes both counters of the bank. The address reads back the run bit only.
- R7: A write to counter address 0xC (counter 0) or 0xD (counter 1) loads the written value. The load takes priority over an event in the same cycle. A zero written right after an event-type write reads back as zero.
- R8: A counter wraps from 0xFFFFFFFF to 0 and sets its overflow bit. Overflow bits are set with write-one at 0x3 and cleared with write-one at 0x4. Both addresses read the overflow bits.
- R9: Interrupt-enable bits are set with write-one at 0x5 and cleared with write-one at 0x6. irq_o is high while any bank has a counter whose overflow bit and interrupt-enable bit are both 1.
- R10: While a bank's power-down input is high, all per-bank reads of it return 0xFFFFFFFF, writes to it change nothing, and its counters hold. After power returns, its earlier values read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| unit_pdn_i | input | 5 | Per-bank power-down (bit 4 = fabric bank) |
| event_i | input | 40 | Event pulses, eight lines per bank, bank b at bits 8b+7..8b |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The hardest state to reach from the ports is a counter wrap, because about four billion events would be needed to get there. The stimulus loads 0xFFFFFFFF through the counter register and then sends a single pulse. A counter load in the same cycle as an event is also hard to reach, since register writes and events normally arrive separately. The bench drives both in one cycle to show that the load wins. The bench also sweeps every bank across every event-type value, including values outside the implemented range. It sends a staircase pulse pattern in which line j pulses j+1 times, so each event type produces a different expected count.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
    localparam int ADDR_W = 4;
    localparam int SEL_W  = 12;

    localparam logic [ADDR_W-1:0] A_SEL      = 4'h0;
    localparam logic [ADDR_W-1:0] A_EN_SET   = 4'h1;
    localparam logic [ADDR_W-1:0] A_EN_CLR   = 4'h2;
    localparam logic [ADDR_W-1:0] A_OVF_SET  = 4'h3;
    localparam logic [ADDR_W-1:0] A_OVF_CLR  = 4'h4;
    localparam logic [ADDR_W-1:0] A_IE_SET   = 4'h5;
    localparam logic [ADDR_W-1:0] A_IE_CLR   = 4'h6;
    localparam logic [ADDR_W-1:0] A_CTRL     = 4'h7;
    localparam logic [ADDR_W-1:0] A_EVT_BASE = 4'h8;
    localparam logic [ADDR_W-1:0] A_CNT_BASE = 4'hC;
endpackage

// File: rtl/pmon_sel_decode.sv
module pmon_sel_decode #(
    parameter int NUM_CL = 4,
    parameter int UW     = 3
) (
    input  logic [pmon_pkg::SEL_W-1:0] sel_i,
    output logic                       hit_o,
    output logic [UW-1:0]              idx_o
);
    logic [3:0] grp;
    logic [7:0] unum;

    always_comb begin
        grp   = sel_i[11:8];
        unum  = sel_i[7:0];
        hit_o = 1'b0;
        idx_o = '0;
        if (grp == 4'd1 && unum < 8'(NUM_CL)) begin
            hit_o = 1'b1;
            idx_o = UW'(unum);
        end else if (grp == 4'd0 && unum == 8'd0) begin
            hit_o = 1'b1;
            idx_o = UW'(NUM_CL);
        end
    end
endmodule

// File: rtl/pmon_unit.sv
module pmon_unit
    import pmon_pkg::*;
#(
    parameter int NCTR    = 2,
    parameter int CW      = 32,
    parameter int NUM_EVT = 8,
    parameter int EVT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CW-1:0]      wdata,
    input  logic               pdn_i,
    input  logic [NUM_EVT-1:0] ev_i,
    output logic [CW-1:0]      rd_data,
    output logic               irq_o
);
    localparam int ESEL_W = $clog2(NUM_EVT);

    typedef struct packed {
        logic                       run;
        logic [NCTR-1:0]            en;
        logic [NCTR-1:0]            ovf;
        logic [NCTR-1:0]            ie;
        logic [NCTR-1:0][EVT_W-1:0] evt;
        logic [NCTR-1:0][CW-1:0]    cnt;
    } unit_st_t;

    unit_st_t st_d, st_q;
    logic [NCTR-1:0] inc, cnt_ld;
    logic            zero_all;

    always_comb begin
        st_d     = st_q;
        zero_all = wr_en && addr == A_CTRL && wdata[1];
        for (int i = 0; i < NCTR; i++) begin
            inc[i] = st_q.run && st_q.en[i] && !pdn_i &&
                     (st_q.evt[i] < EVT_W'(NUM_EVT)) &&
                     ev_i[st_q.evt[i][ESEL_W-1:0]];
            cnt_ld[i] = wr_en && addr == (A_CNT_BASE + ADDR_W'(i));
        end
        if (wr_en) begin
            case (addr)
                A_EN_SET:  st_d.en  = st_q.en  |  wdata[NCTR-1:0];
                A_EN_CLR:  st_d.en  = st_q.en  & ~wdata[NCTR-1:0];
                A_OVF_SET: st_d.ovf = st_q.ovf |  wdata[NCTR-1:0];
                A_OVF_CLR: st_d.ovf = st_q.ovf & ~wdata[NCTR-1:0];
                A_IE_SET:  st_d.ie  = st_q.ie  |  wdata[NCTR-1:0];
                A_IE_CLR:  st_d.ie  = st_q.ie  & ~wdata[NCTR-1:0];
                A_CTRL:    st_d.run = wdata[0];
                default: ;
            endcase
            for (int i = 0; i < NCTR; i++)
                if (addr == (A_EVT_BASE + ADDR_W'(i)))
                    st_d.evt[i] = wdata[EVT_W-1:0];
        end
        for (int i = 0; i < NCTR; i++) begin
            if (cnt_ld[i]) begin
                st_d.cnt[i] = wdata;
            end else if (zero_all) begin
                st_d.cnt[i] = '0;
            end else if (inc[i]) begin
                st_d.cnt[i] = st_q.cnt[i] + 1'b1;
                if (&st_q.cnt[i]) st_d.ovf[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            A_EN_SET, A_EN_CLR:   rd_data = CW'(st_q.en);
            A_OVF_SET, A_OVF_CLR: rd_data = CW'(st_q.ovf);
            A_IE_SET, A_IE_CLR:   rd_data = CW'(st_q.ie);
            A_CTRL:               rd_data = CW'(st_q.run);
            default: ;
        endcase
        for (int i = 0; i < NCTR; i++) begin
            if (addr == (A_EVT_BASE + ADDR_W'(i))) rd_data = CW'(st_q.evt[i]);
            if (addr == (A_CNT_BASE + ADDR_W'(i))) rd_data = st_q.cnt[i];
        end
    end

    assign irq_o = |(st_q.ovf & st_q.ie);

    // Control bits move only on a write to this bank (R5, R9)
    assert_ctl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(st_q.en) && $stable(st_q.ie) && $stable(st_q.run)));

    // The interrupt needs a pending overflow (R9)
    assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|st_q.ovf));

    for (genvar g = 0; g < NCTR; g++) begin : g_chk
        // A powered-down bank holds its counters (R10)
        assert_pdn_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $past(pdn_i) |-> $stable(st_q.cnt[g]));
        // Without a write, a counter steps by at most one (R3)
        assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(wr_en) |-> (st_q.cnt[g] == $past(st_q.cnt[g]) ||
                               st_q.cnt[g] == $past(st_q.cnt[g]) + 1'b1));
        // A wrap raises the overflow bit (R8)
        assert_wrap_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(inc[g]) && $past(&st_q.cnt[g]) && !$past(wr_en)) |->
            (st_q.ovf[g] && st_q.cnt[g] == '0));
    end
endmodule

// File: rtl/uncore_perfmon_bank.sv
module uncore_perfmon_bank
    import pmon_pkg::*;
#(
    parameter int NUM_CL  = 4,
    parameter int NCTR    = 2,
    parameter int CW      = 32,
    parameter int NUM_EVT = 8,
    parameter int EVT_W   = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_wr_i,
    input  logic [ADDR_W-1:0]                 reg_addr_i,
    input  logic [CW-1:0]                     reg_wdata_i,
    output logic [CW-1:0]                     reg_rdata_o,
    input  logic [NUM_CL:0]                   unit_pdn_i,
    input  logic [(NUM_CL+1)*NUM_EVT-1:0]     event_i,
    output logic                              irq_o
);
    localparam int NUNITS = NUM_CL + 1;
    localparam int UW     = $clog2(NUNITS);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
    } top_st_t;

    top_st_t top_d, top_q;
    logic                         sel_hit;
    logic [UW-1:0]                sel_idx;
    logic [NUNITS-1:0]            unit_we, unit_irq;
    logic [NUNITS-1:0][CW-1:0]    unit_rd;

    always_comb begin
        top_d = top_q;
        if (reg_wr_i && reg_addr_i == A_SEL) top_d.sel = reg_wdata_i[SEL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    pmon_sel_decode #(.NUM_CL(NUM_CL), .UW(UW)) u_dec (
        .sel_i (top_q.sel),
        .hit_o (sel_hit),
        .idx_o (sel_idx)
    );

    for (genvar u = 0; u < NUNITS; u++) begin : g_unit
        assign unit_we[u] = reg_wr_i && reg_addr_i != A_SEL && sel_hit &&
                            sel_idx == UW'(u) && !unit_pdn_i[u];
        pmon_unit #(.NCTR(NCTR), .CW(CW), .NUM_EVT(NUM_EVT), .EVT_W(EVT_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (unit_we[u]),
            .addr    (reg_addr_i),
            .wdata   (reg_wdata_i),
            .pdn_i   (unit_pdn_i[u]),
            .ev_i    (event_i[u*NUM_EVT +: NUM_EVT]),
            .rd_data (unit_rd[u]),
            .irq_o   (unit_irq[u])
        );
    end

    always_comb begin
        if (reg_addr_i == A_SEL)      reg_rdata_o = CW'(top_q.sel);
        else if (!sel_hit)            reg_rdata_o = '0;
        else if (unit_pdn_i[sel_idx]) reg_rdata_o = '1;
        else                          reg_rdata_o = unit_rd[sel_idx];
    end

    assign irq_o = |unit_irq;

    // At most one bank takes a write (R1)
    assert_one_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unit_we));
endmodule

// File: tb/uncore_perfmon_bank_tb.sv
module uncore_perfmon_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [3:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [4:0]  unit_pdn_i = '0;
    logic [39:0] event_i = '0;
    logic        irq_o;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    uncore_perfmon_bank u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .unit_pdn_i(unit_pdn_i), .event_i(event_i), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(posedge clk); #1;
        reg_wr_i = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr_i = a;
        #1;
        chk(req, reg_rdata_o, exp);
    endtask

    task automatic pulse(input logic [39:0] v);
        @(negedge clk);
        event_i = v;
        @(posedge clk); #1;
        event_i = '0;
    endtask

    function automatic logic [31:0] sel_of(input int u);
        return (u < 4) ? (32'h100 | 32'(u)) : 32'h0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 reset state
        rd_chk("R2 sel", 4'h0, 32'h0);
        for (int u = 0; u < 5; u++) begin
            wr(4'h0, sel_of(u));
            rd_chk("R1 sel readback", 4'h0, sel_of(u));
            rd_chk("R2 cnt0", 4'hC, 32'h0);
            rd_chk("R2 en", 4'h1, 32'h0);
            rd_chk("R2 ctrl", 4'h7, 32'h0);
        end
        chk("R2 irq", 32'(irq_o), 32'h0);

        // R3/R4 sweep: every bank, every event type; line j pulses j+1 times
        for (int u = 0; u < 5; u++) begin
            wr(4'h0, sel_of(u));
            wr(4'h7, 32'h1);
            wr(4'h1, 32'h3);
            for (int t = 0; t < 10; t++) begin
                wr(4'h8, 32'(t));
                wr(4'hC, 32'h0);
                rd_chk("R7 zero after type write", 4'hC, 32'h0);
                for (int c = 0; c < 8; c++) begin
                    logic [7:0] pat;
                    for (int j = 0; j < 8; j++) pat[j] = (c <= j);
                    pulse(40'(pat) << (u * 8));
                end
                rd_chk("R3 R4 count", 4'hC, (t < 8) ? 32'(t + 1) : 32'h0);
            end
        end

        // R5 write-one enable semantics on cluster bank 1
        wr(4'h0, 32'h101);
        wr(4'h8, 32'h0);
        wr(4'hC, 32'h0);
        wr(4'h2, 32'h0);
        rd_chk("R5 clear zero no effect", 4'h1, 32'h3);
        wr(4'h2, 32'h2);
        rd_chk("R5 clear bit1", 4'h2, 32'h1);
        wr(4'h1, 32'h0);
        rd_chk("R5 set zero no effect", 4'h1, 32'h1);

        // R3 gating: run off, then enable off
        wr(4'h7, 32'h0);
        pulse(40'h1 << 8);
        rd_chk("R3 run off", 4'hC, 32'h0);
        wr(4'h7, 32'h1);
        pulse(40'h1 << 8);
        rd_chk("R3 run on", 4'hC, 32'h1);
        wr(4'h2, 32'h1);
        pulse(40'h1 << 8);
        rd_chk("R3 enable off", 4'hC, 32'h1);
        wr(4'h1, 32'h1);
        pulse(40'h1 << 0);
        rd_chk("R3 other bank line", 4'hC, 32'h1);

        // R6 counter reset through control
        wr(4'hD, 32'h1234);
        wr(4'h7, 32'h3);
        rd_chk("R6 reset cnt0", 4'hC, 32'h0);
        rd_chk("R6 reset cnt1", 4'hD, 32'h0);
        rd_chk("R6 ctrl readback", 4'h7, 32'h1);

        // R8 wrap and overflow, R9 interrupt
        wr(4'hC, 32'hFFFF_FFFF);
        pulse(40'h1 << 8);
        rd_chk("R8 wrap to zero", 4'hC, 32'h0);
        rd_chk("R8 overflow set", 4'h3, 32'h1);
        chk("R9 irq masked", 32'(irq_o), 32'h0);
        wr(4'h5, 32'h1);
        chk("R9 irq on", 32'(irq_o), 32'h1);
        wr(4'h4, 32'h1);
        rd_chk("R8 overflow clear", 4'h4, 32'h0);
        chk("R9 irq off", 32'(irq_o), 32'h0);
        wr(4'h3, 32'h2);
        chk("R9 irq other bit", 32'(irq_o), 32'h0);
        wr(4'h5, 32'h2);
        chk("R9 irq bit1", 32'(irq_o), 32'h1);
        wr(4'h6, 32'h3);
        rd_chk("R9 ie clear", 4'h5, 32'h0);
        chk("R9 irq cleared", 32'(irq_o), 32'h0);

        // R7 load beats a same-cycle event
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = 4'hC; reg_wdata_i = 32'h55;
        event_i = 40'h1 << 8;
        @(posedge clk); #1;
        reg_wr_i = 1'b0; event_i = '0;
        rd_chk("R7 load wins", 4'hC, 32'h55);

        // R10 power-down
        unit_pdn_i = 5'b00010;
        rd_chk("R10 cnt reads ones", 4'hC, 32'hFFFF_FFFF);
        rd_chk("R10 en reads ones", 4'h1, 32'hFFFF_FFFF);
        wr(4'hC, 32'h77);
        pulse(40'h1 << 8);
        @(negedge clk);
        unit_pdn_i = 5'b0;
        rd_chk("R10 held after power", 4'hC, 32'h55);

        // R1 unmatched selects
        wr(4'h0, 32'h105);
        rd_chk("R1 sel readback", 4'h0, 32'h105);
        rd_chk("R1 nohit read", 4'hC, 32'h0);
        wr(4'hC, 32'h99);
        wr(4'h0, 32'h001);
        rd_chk("R1 nohit read 001", 4'hC, 32'h0);
        wr(4'hC, 32'h98);
        wr(4'h0, 32'h200);
        wr(4'hC, 32'h97);
        wr(4'h0, 32'h101);
        rd_chk("R1 write ignored", 4'hC, 32'h55);
        wr(4'h0, 32'h000);
        rd_chk("R1 fabric untouched", 4'hC, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule